// File: doc/BRIEF.md
# SDRAM Power-Up Initialization Sequencer

This block brings an SDRAM device out of power-up. After reset is released and an asynchronous start enable has passed through a two-flop synchronizer, it waits a parameterized number of clock cycles and then asks a shared command sequencer for a fixed series of commands: a precharge of all banks, a parameterized number of auto-refresh cycles, and finally a mode-register load. It drives no memory pin itself. Every command is a request that stays up with a stable code until the sequencer acknowledges it, and only one request is outstanding at any time.

The mode-register word is a constant built from parameters for read latency, burst length, burst ordering and single-write mode. Reserved positions are always zero. Once the mode load has been acknowledged, the block raises a done flag that stays high until the next reset. Downstream, that flag releases periodic refresh and normal data traffic. If the enable is tied high, the sequence starts directly on reset release.

Top module: `sdram_init_seq`

## Requirements
- R1: While reset is asserted, and on the first sample after it, `cmd_req`, `init_done` and `cmd_code` are all 0.
- R2: While the synchronized enable has never been high since reset, `cmd_req` stays 0 and pulses on `cmd_ack` have no effect.
- R3: The first request rises exactly WAIT_CYCLES+3 rising edges after the first edge that samples `en_async` high, counting that edge as 1. The three extra cycles are two synchronizer stages and one start cycle. `cmd_ack` pulses during the wait do not shift this.
- R4: Command codes are issued in this order: precharge-all (code 1), then REFRESHES auto-refresh requests (code 2, two by default), then mode load (code 3).
- R5: A request keeps `cmd_req` high and `cmd_code` unchanged until a clock edge samples `cmd_ack` high.
- R6: In the cycle after an acknowledging edge, the next command's code is already presented with `cmd_req` still high. After the last command, `init_done` is high and `cmd_req` is low.
- R7: Once high, `init_done` stays high and `cmd_req` stays low until reset, whatever `en_async` and `cmd_ack` do.
- R8: `mode_word` holds the burst length code in bits 2:0 (1→0, 2→1, 4→2, 8→3, full page→7), the interleaved ordering flag in bit 3, the read latency in bits 6:4, single-write mode in bit 9, and 0 in bits 8:7 and in every bit above 9.
- R9: Dropping `en_async` after the enable has been sampled and the wait has begun does not stop or delay the sequence.
- R10: Asserting reset in the middle of the sequence abandons it. After release, the whole sequence runs again from the wait.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en_async | input | 1 | Asynchronous start enable, synchronized inside |
| cmd_ack | input | 1 | Sequencer accepts the current request on a sampled high |
| cmd_req | output | 1 | A command request is pending |
| cmd_code | output | 2 | Requested command: 1 precharge all, 2 auto refresh, 3 mode load, 0 none |
| mode_word | output | MODE_W | Mode-register value for the load command |
| init_done | output | 1 | Initialization complete, sticky until reset |

## Verification
The first request is due a fixed WAIT_CYCLES+3 edges after the edge that first samples the enable. The bench therefore counts edges from that point and checks for the request at the negative edge that follows the expected edge. Every later result is due one edge after the acknowledging edge. The bench drives `cmd_ack` at a negative edge, steps over exactly one rising edge, and compares code, request and done at the next negative edge. Between acknowledgements it holds off for a random number of cycles and checks at each negative edge that the request has not moved.

// File: rtl/sdram_init_seq.sv
module sdram_init_seq #(
  parameter int WAIT_CYCLES = 5000,
  parameter int REFRESHES   = 2,
  parameter int MODE_W      = 13,
  parameter int CAS_LAT     = 3,
  parameter int BURST_LEN   = 8,
  parameter bit INTERLEAVE  = 1'b0,
  parameter bit SINGLE_WR   = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en_async,
  input  logic              cmd_ack,
  output logic              cmd_req,
  output logic [1:0]        cmd_code,
  output logic [MODE_W-1:0] mode_word,
  output logic              init_done
);

  localparam int WCW = $clog2(WAIT_CYCLES + 1);
  localparam int RCW = $clog2(REFRESHES + 1);
  localparam int BL_CODE = (BURST_LEN == 1) ? 0 :
                           (BURST_LEN == 2) ? 1 :
                           (BURST_LEN == 4) ? 2 :
                           (BURST_LEN == 8) ? 3 : 7;
  localparam int MODE_INT = (int'(SINGLE_WR) << 9) | ((CAS_LAT & 7) << 4) |
                            (int'(INTERLEAVE) << 3) | BL_CODE;

  typedef enum logic [2:0] {S_IDLE, S_WAIT, S_PRE, S_REF, S_LMR, S_DONE} state_t;

  state_t          state;
  logic            en_s1, en_s2;
  logic [WCW-1:0]  wcnt;
  logic [RCW-1:0]  rcnt;

  assign mode_word = MODE_W'(MODE_INT);
  assign cmd_req   = (state == S_PRE) || (state == S_REF) || (state == S_LMR);
  assign cmd_code  = (state == S_PRE) ? 2'd1 :
                     (state == S_REF) ? 2'd2 :
                     (state == S_LMR) ? 2'd3 : 2'd0;
  assign init_done = (state == S_DONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_s1 <= 1'b0;
      en_s2 <= 1'b0;
    end else begin
      en_s1 <= en_async;
      en_s2 <= en_s1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_IDLE;
      wcnt  <= '0;
      rcnt  <= '0;
    end else begin
      case (state)
        S_IDLE: if (en_s2) begin
          state <= S_WAIT;
          wcnt  <= WCW'(WAIT_CYCLES - 1);
        end
        S_WAIT: begin
          if (wcnt == '0) state <= S_PRE;
          else            wcnt  <= wcnt - 1'b1;
        end
        S_PRE: if (cmd_ack) begin
          state <= S_REF;
          rcnt  <= RCW'(REFRESHES - 1);
        end
        S_REF: if (cmd_ack) begin
          if (rcnt == '0) state <= S_LMR;
          else            rcnt  <= rcnt - 1'b1;
        end
        S_LMR:   if (cmd_ack) state <= S_DONE;
        S_DONE:  state <= S_DONE;
        default: state <= S_IDLE;
      endcase
    end
  end

  // R5
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_req && !cmd_ack) |=> (cmd_req && $stable(cmd_code)));

  // R7
  done_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    init_done |=> (init_done && !cmd_req));

  // R6
  done_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(init_done) |-> $past(cmd_req && cmd_ack && cmd_code == 2'd3));

  // R4
  first_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cmd_req) |-> (cmd_code == 2'd1));

  // R2
  no_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_s2 && state == S_IDLE) |=> !cmd_req);

endmodule

// File: tb/sdram_init_seq_tb.sv
module sdram_init_seq_tb_top;
  localparam int W = 5000;
  localparam int NREF = 2;

  logic clk = 1'b0, rst_n = 1'b0, en_async = 1'b0, cmd_ack = 1'b0;
  logic cmd_req, init_done;
  logic [1:0] cmd_code;
  logic [12:0] mode_word;
  int tests = 0, fails = 0, cycles = 0;

  always #10 clk = ~clk;

  sdram_init_seq dut_i (
    .clk(clk), .rst_n(rst_n), .en_async(en_async), .cmd_ack(cmd_ack),
    .cmd_req(cmd_req), .cmd_code(cmd_code), .mode_word(mode_word),
    .init_done(init_done));

  always @(posedge clk) begin
    cycles++;
    if (cycles > 190000) begin
      fails++; tests++;
      $display("FAIL watchdog: actual %0d cycles expected < 190000", cycles);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  task automatic chk(input string r, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", r, act, exp);
    end
  endtask

  function automatic int exp_code(input int i);
    return (i == 0) ? 1 : (i <= NREF) ? 2 : 3;
  endfunction

  function automatic int exp_mode(input int cas, input int bl, input int il, input int sw);
    int blc;
    blc = (bl == 1) ? 0 : (bl == 2) ? 1 : (bl == 4) ? 2 : (bl == 8) ? 3 : 7;
    return (sw << 9) | (cas << 4) | (il << 3) | blc;
  endfunction

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0; en_async = 1'b0; cmd_ack = 1'b0;
    repeat (2) @(negedge clk);
    chk("R1 req in reset", cmd_req, 0);
    chk("R1 done in reset", init_done, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 code after reset", cmd_code, 0);
  endtask

  task automatic start_wait(input bit drop_en, input bit noise);
    int n = 0;
    en_async = 1'b1;
    while (!cmd_req && n < W + 20) begin
      @(posedge clk); n++;
      @(negedge clk);
      if (drop_en && n == 6) en_async = 1'b0;
      cmd_ack = noise && (n % 7 == 0);
    end
    cmd_ack = 1'b0;
    chk(drop_en ? "R9 start edge with enable dropped" :
        noise ? "R3 start edge with ack noise" : "R3 start edge", n, W + 3);
  endtask

  task automatic run_cmds(input int stop_after);
    for (int i = 0; i <= NREF + 1 && i < stop_after; i++) begin
      int d = $urandom_range(0, 4);
      int bad = 0;
      chk("R4 command order", cmd_code, exp_code(i));
      for (int k = 0; k < d; k++) begin
        @(posedge clk); @(negedge clk);
        if (!cmd_req || cmd_code != exp_code(i)) bad++;
      end
      chk("R5 request held until ack", bad, 0);
      cmd_ack = 1'b1;
      @(posedge clk); @(negedge clk);
      cmd_ack = 1'b0;
      if (i < NREF + 1) begin
        chk("R6 next request after ack", cmd_req, 1);
        chk("R6 next code after ack", cmd_code, exp_code(i + 1));
      end else begin
        chk("R6 done after mode load ack", init_done, 1);
        chk("R6 request low after done", cmd_req, 0);
      end
    end
  endtask

  initial begin
    int bad;
    void'($urandom(32'd17));
    do_reset();
    chk("R8 mode word", mode_word, exp_mode(3, 8, 0, 0));

    bad = 0;
    for (int k = 0; k < 300; k++) begin
      cmd_ack = k[2] ^ k[0];
      @(posedge clk); @(negedge clk);
      if (cmd_req || init_done) bad++;
    end
    cmd_ack = 1'b0;
    chk("R2 idle without enable", bad, 0);

    start_wait(1'b0, 1'b1);
    run_cmds(99);

    bad = 0;
    en_async = 1'b0;
    for (int k = 0; k < 50; k++) begin
      cmd_ack = $urandom_range(0, 1);
      @(posedge clk); @(negedge clk);
      if (!init_done || cmd_req) bad++;
    end
    cmd_ack = 1'b0;
    chk("R7 done sticky, no request", bad, 0);

    do_reset();
    start_wait(1'b1, 1'b0);
    run_cmds(99);

    do_reset();
    start_wait(1'b0, 1'b0);
    run_cmds(2);
    do_reset();
    chk("R10 no request after mid reset", cmd_req, 0);
    start_wait(1'b0, 1'b0);
    run_cmds(99);
    chk("R10 sequence completes after restart", init_done, 1);

    for (int r = 0; r < 3; r++) begin
      do_reset();
      repeat ($urandom_range(0, 10)) @(negedge clk);
      start_wait(1'b0, r[0]);
      run_cmds(99);
    end

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule